// File: doc/BRIEF.md
# Pipelined Bus Wait-State Controller

This block sequences the CPU side of a memory bus whose target is page-mode DRAM. A requester offers one access at a time (address and direction). The controller captures it and steps it through a one-cycle address state (T1) and one or more data states (T2). It repeats T2 as wait states until the memory has had enough time, and then returns a single-cycle ready strobe. The number of wait states depends on two things: whether the access falls in the DRAM page left open by the previous access, and whether the address of the access was accepted early.

Early acceptance is the next-address pipelining mode. When `pipe_en` is high and a request is waiting while an access sits in T2, the controller acknowledges it at once and holds it as the pending access. That access starts its T1 right after the current ready, and its address has been known for longer, so it needs one wait state fewer. If no request is waiting when an access finishes, the controller goes back to idle, and the next access runs in the non-pipelined form again.

States: `ST_IDLE` (no access), `ST_T1` (address state), `ST_T2` (data state, repeated for wait states). Transitions: IDLE→T1 when a request is captured; T1→T2 always; T2→T2 while wait states remain; T2→T1 at ready when a pending or newly captured access exists; T2→IDLE at ready otherwise.

Top module: `bwc_bus_ctrl`

## Requirements
- R1: During and after reset the controller is in IDLE. `bus_t1`, `bus_t2`, `bus_wait`, `ready`, `next_addr_ack`, `req_take` and `page_hit` are all low, and no page counts as open.
- R2: In IDLE, a high `req_valid` raises `req_take` in that same cycle. The next cycle is T1, and `bus_addr`/`bus_write` carry the captured request.
- R3: Every access spends exactly one cycle in T1 and then one or more cycles in T2. `bus_wait` is high on every T2 except the last one. `ready` is high for exactly one cycle, on the last T2.
- R4: A non-pipelined access gets two wait states on a page miss and one wait state on a page hit.
- R5: A pipelined access gets one wait state on a page miss and none on a page hit.
- R6: The page is the address bits above the low `COL_W` bits. An access hits when its page equals the page of the access that precedes it (the one completing before it). The first access after reset is always a miss, even for page 0.
- R7: With `pipe_en` high, a `req_valid` seen in any T2 while nothing is pending raises both `next_addr_ack` and `req_take`. That access is pipelined and enters T1 in the cycle after the current `ready`.
- R8: With `pipe_en` low, a `req_valid` seen in the final T2 (while nothing is pending) raises `req_take` but not `next_addr_ack`. That access is non-pipelined and enters T1 in the next cycle.
- R9: At most one access is pending. While one is held, `req_valid` during T2 is ignored (`req_take` stays low) and the held address is the one that runs next.
- R10: When no access is pending or captured at `ready`, the controller returns to IDLE. An access captured from IDLE is always non-pipelined, even with `pipe_en` high.
- R11: `page_hit` is high throughout T1 and T2 of an access that hits, and low in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | An access request is offered |
| req_addr | input | AW | Address of the offered request |
| req_write | input | 1 | Offered request is a write (1) or read (0) |
| pipe_en | input | 1 | Allow next-address pipelining |
| req_take | output | 1 | Offered request is captured at the coming edge |
| bus_addr | output | AW | Address of the access on the bus |
| bus_write | output | 1 | Direction of the access on the bus |
| bus_t1 | output | 1 | Bus is in the address state T1 |
| bus_t2 | output | 1 | Bus is in a data state T2 (including wait states) |
| bus_wait | output | 1 | Current T2 is a wait state |
| ready | output | 1 | Access completes in this cycle |
| next_addr_ack | output | 1 | Offered request accepted early as a pipelined access |
| page_hit | output | 1 | Current access falls in the open DRAM page |

## Verification
The assertions assume the requester keeps `req_valid`, `req_addr` and `req_write` steady within a cycle and changes them only away from the clock edge. They also assume it treats `req_take` as the only sign that its request was consumed. The stimulus drives all inputs on the falling edge and drops `req_valid` in the cycle after each capture, except where a second offer is made on purpose to show it is ignored. Reset is asserted once in the middle of an access. This checks that the asynchronous return to IDLE and the cleared open page hold together.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_T2   = 2'd2
    } bus_state_t;

endpackage

// File: rtl/bwc_page_track.sv
module bwc_page_track #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          update,
    input  logic [PW-1:0] cur_page,
    input  logic          busy,
    input  logic [PW-1:0] cand_page,
    output logic          cand_hit
);

    logic [PW-1:0] open_page;
    logic          open_valid;
    logic [PW-1:0] ref_page;
    logic          ref_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_page  <= '0;
            open_valid <= 1'b0;
        end else if (update) begin
            open_page  <= cur_page;
            open_valid <= 1'b1;
        end
    end

    // A candidate captured during an access runs after that access completes.
    always_comb begin
        ref_page  = busy ? cur_page : open_page;
        ref_valid = busy | open_valid;
        cand_hit  = ref_valid && (cand_page == ref_page);
    end

    assert_open_after_update_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        update |=> (open_valid && open_page == $past(cur_page))
    );

endmodule

// File: rtl/bwc_wait_calc.sv
module bwc_wait_calc #(
    parameter int MISS_WAITS = 2,
    parameter int HIT_WAITS  = 1,
    parameter int PIPE_SAVE  = 1,
    parameter int WW         = 2
) (
    input  logic          hit,
    input  logic          pipelined,
    output logic [WW-1:0] waits
);

    localparam int MISS_PIPE = (MISS_WAITS > PIPE_SAVE) ? MISS_WAITS - PIPE_SAVE : 0;
    localparam int HIT_PIPE  = (HIT_WAITS  > PIPE_SAVE) ? HIT_WAITS  - PIPE_SAVE : 0;

    always_comb begin
        unique case ({pipelined, hit})
            2'b00:   waits = WW'(MISS_WAITS);
            2'b01:   waits = WW'(HIT_WAITS);
            2'b10:   waits = WW'(MISS_PIPE);
            default: waits = WW'(HIT_PIPE);
        endcase
    end

endmodule

// File: rtl/bwc_bus_ctrl.sv
module bwc_bus_ctrl
    import bwc_pkg::*;
#(
    parameter int AW         = 16,
    parameter int COL_W      = 8,
    parameter int MISS_WAITS = 2,
    parameter int HIT_WAITS  = 1,
    parameter int PIPE_SAVE  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic          pipe_en,
    output logic          req_take,
    output logic [AW-1:0] bus_addr,
    output logic          bus_write,
    output logic          bus_t1,
    output logic          bus_t2,
    output logic          bus_wait,
    output logic          ready,
    output logic          next_addr_ack,
    output logic          page_hit
);

    localparam int PW = AW - COL_W;
    localparam int WW = ($clog2(MISS_WAITS + 1) < 1) ? 1 : $clog2(MISS_WAITS + 1);

    bus_state_t    st, st_n;
    logic [WW-1:0] wcnt, wcnt_n;
    logic [AW-1:0] cur_addr, cur_addr_n, nxt_addr, nxt_addr_n;
    logic          cur_wr, cur_wr_n, nxt_wr, nxt_wr_n;
    logic          cur_hit, cur_hit_n, nxt_hit, nxt_hit_n;
    logic          nxt_valid, nxt_valid_n;
    logic [WW-1:0] nxt_waits, nxt_waits_n;

    logic          final_t2, pipe_cap, plain_cap, take;
    logic          cand_hit;
    logic [WW-1:0] cand_waits;

    assign final_t2  = (st == ST_T2) && (wcnt == '0);
    assign pipe_cap  = (st == ST_T2) && pipe_en && req_valid && !nxt_valid;
    assign plain_cap = ((st == ST_IDLE) && req_valid) ||
                       (final_t2 && !pipe_en && req_valid && !nxt_valid);
    assign take      = pipe_cap | plain_cap;

    bwc_page_track #(.PW(PW)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .update   (final_t2),
        .cur_page (cur_addr[AW-1:COL_W]),
        .busy     (st != ST_IDLE),
        .cand_page(req_addr[AW-1:COL_W]),
        .cand_hit (cand_hit)
    );

    bwc_wait_calc #(
        .MISS_WAITS(MISS_WAITS),
        .HIT_WAITS (HIT_WAITS),
        .PIPE_SAVE (PIPE_SAVE),
        .WW        (WW)
    ) u_wait (
        .hit      (cand_hit),
        .pipelined(pipe_cap),
        .waits    (cand_waits)
    );

    // Next-state and register-load decisions
    always_comb begin
        st_n        = st;
        wcnt_n      = wcnt;
        cur_addr_n  = cur_addr;
        cur_wr_n    = cur_wr;
        cur_hit_n   = cur_hit;
        nxt_valid_n = nxt_valid;
        nxt_addr_n  = nxt_addr;
        nxt_wr_n    = nxt_wr;
        nxt_hit_n   = nxt_hit;
        nxt_waits_n = nxt_waits;
        unique case (st)
            ST_IDLE: begin
                if (take) begin
                    st_n       = ST_T1;
                    cur_addr_n = req_addr;
                    cur_wr_n   = req_write;
                    cur_hit_n  = cand_hit;
                    wcnt_n     = cand_waits;
                end
            end
            ST_T1: begin
                st_n = ST_T2;
            end
            ST_T2: begin
                if (wcnt != '0) begin
                    wcnt_n = wcnt - WW'(1);
                    if (pipe_cap) begin
                        nxt_valid_n = 1'b1;
                        nxt_addr_n  = req_addr;
                        nxt_wr_n    = req_write;
                        nxt_hit_n   = cand_hit;
                        nxt_waits_n = cand_waits;
                    end
                end else if (nxt_valid) begin
                    st_n        = ST_T1;
                    cur_addr_n  = nxt_addr;
                    cur_wr_n    = nxt_wr;
                    cur_hit_n   = nxt_hit;
                    wcnt_n      = nxt_waits;
                    nxt_valid_n = 1'b0;
                end else if (take) begin
                    st_n       = ST_T1;
                    cur_addr_n = req_addr;
                    cur_wr_n   = req_write;
                    cur_hit_n  = cand_hit;
                    wcnt_n     = cand_waits;
                end else begin
                    st_n = ST_IDLE;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            wcnt      <= '0;
            cur_addr  <= '0;
            cur_wr    <= 1'b0;
            cur_hit   <= 1'b0;
            nxt_valid <= 1'b0;
            nxt_addr  <= '0;
            nxt_wr    <= 1'b0;
            nxt_hit   <= 1'b0;
            nxt_waits <= '0;
        end else begin
            st        <= st_n;
            wcnt      <= wcnt_n;
            cur_addr  <= cur_addr_n;
            cur_wr    <= cur_wr_n;
            cur_hit   <= cur_hit_n;
            nxt_valid <= nxt_valid_n;
            nxt_addr  <= nxt_addr_n;
            nxt_wr    <= nxt_wr_n;
            nxt_hit   <= nxt_hit_n;
            nxt_waits <= nxt_waits_n;
        end
    end

    // Outputs
    always_comb begin
        bus_t1        = (st == ST_T1);
        bus_t2        = (st == ST_T2);
        bus_wait      = (st == ST_T2) && (wcnt != '0);
        ready         = final_t2;
        next_addr_ack = pipe_cap;
        req_take      = take;
        page_hit      = (st != ST_IDLE) && cur_hit;
        bus_addr      = cur_addr;
        bus_write     = cur_wr;
    end

    assert_idle_capture_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        ((st == ST_IDLE) && req_valid) |=> (bus_t1 && bus_addr == $past(req_addr))
    );

    assert_t1_single_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        bus_t1 |=> bus_t2
    );

    assert_ready_single_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        ready |=> !ready
    );

    assert_wait_then_t2_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        bus_wait |=> bus_t2
    );

    assert_miss_has_wait_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (bus_t1 && !page_hit) |=> bus_wait
    );

    assert_single_pending_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (next_addr_ack && !ready) |=> !next_addr_ack
    );

    assert_idle_no_hit_R11: assert property (
        @(posedge clk) disable iff (!rst_n)
        (!bus_t1 && !bus_t2) |-> !page_hit
    );

endmodule

// File: tb/bwc_bus_ctrl_test.sv
module bwc_bus_ctrl_test;

    localparam int AW = 16;
    localparam int NV = 27;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          pipe_en = 1'b0;
    logic          req_take, bus_write, bus_t1, bus_t2, bus_wait, ready, next_addr_ack, page_hit;
    logic [AW-1:0] bus_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bwc_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .pipe_en(pipe_en), .req_take(req_take),
        .bus_addr(bus_addr), .bus_write(bus_write), .bus_t1(bus_t1), .bus_t2(bus_t2),
        .bus_wait(bus_wait), .ready(ready), .next_addr_ack(next_addr_ack),
        .page_hit(page_hit)
    );

    // {valid, pipe, write, addr} {t1,t2,wait,ready,nack,take,hit} {write, addr}
    localparam logic [42:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,16'h1234, 7'b0000010, 1'b0,16'h0000},
        {1'b0,1'b0,1'b0,16'h0000, 7'b1000000, 1'b0,16'h1234},
        {1'b0,1'b0,1'b0,16'h0000, 7'b0110000, 1'b0,16'h1234},
        {1'b0,1'b0,1'b0,16'h0000, 7'b0110000, 1'b0,16'h1234},
        {1'b0,1'b0,1'b0,16'h0000, 7'b0101000, 1'b0,16'h1234},
        {1'b1,1'b0,1'b1,16'h1250, 7'b0000010, 1'b0,16'h0000},
        {1'b0,1'b0,1'b0,16'h0000, 7'b1000001, 1'b1,16'h1250},
        {1'b0,1'b0,1'b0,16'h0000, 7'b0110001, 1'b1,16'h1250},
        {1'b1,1'b0,1'b0,16'h3300, 7'b0101011, 1'b1,16'h1250},
        {1'b0,1'b0,1'b0,16'h0000, 7'b1000000, 1'b0,16'h3300},
        {1'b0,1'b0,1'b0,16'h0000, 7'b0110000, 1'b0,16'h3300},
        {1'b0,1'b0,1'b0,16'h0000, 7'b0110000, 1'b0,16'h3300},
        {1'b0,1'b0,1'b0,16'h0000, 7'b0101000, 1'b0,16'h3300},
        {1'b1,1'b1,1'b1,16'h3340, 7'b0000010, 1'b0,16'h0000},
        {1'b0,1'b1,1'b0,16'h0000, 7'b1000001, 1'b1,16'h3340},
        {1'b1,1'b1,1'b0,16'h3380, 7'b0110111, 1'b1,16'h3340},
        {1'b1,1'b1,1'b1,16'h7777, 7'b0101001, 1'b1,16'h3340},
        {1'b0,1'b1,1'b0,16'h0000, 7'b1000001, 1'b0,16'h3380},
        {1'b1,1'b1,1'b1,16'h5000, 7'b0101111, 1'b0,16'h3380},
        {1'b0,1'b1,1'b0,16'h0000, 7'b1000000, 1'b1,16'h5000},
        {1'b0,1'b1,1'b0,16'h0000, 7'b0110000, 1'b1,16'h5000},
        {1'b0,1'b1,1'b0,16'h0000, 7'b0101000, 1'b1,16'h5000},
        {1'b1,1'b1,1'b0,16'h5010, 7'b0000010, 1'b0,16'h0000},
        {1'b0,1'b1,1'b0,16'h0000, 7'b1000001, 1'b0,16'h5010},
        {1'b0,1'b1,1'b0,16'h0000, 7'b0110001, 1'b0,16'h5010},
        {1'b0,1'b1,1'b0,16'h0000, 7'b0101001, 1'b0,16'h5010},
        {1'b0,1'b0,1'b0,16'h0000, 7'b0000000, 1'b0,16'h0000}
    };

    function automatic string vec_req(int i);
        case (i)
            0, 5, 13:            return "R2";
            1, 2, 3, 4, 6, 7:    return "R4";
            8, 9, 10, 11, 12:    return "R8";
            14:                  return "R11";
            15:                  return "R7";
            16:                  return "R9";
            17, 18, 19, 20, 21:  return "R5";
            default:             return "R10";
        endcase
    endfunction

    function automatic logic [6:0] flags();
        return {bus_t1, bus_t2, bus_wait, ready, next_addr_ack, req_take, page_hit};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        #4000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        // R1: idle after reset
        check(flags() == 7'b0, "R1", 32'(flags()), 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            req_valid = VEC[i][42];
            pipe_en   = VEC[i][41];
            req_write = VEC[i][40];
            req_addr  = VEC[i][39:24];
            #5;
            check(flags() == VEC[i][23:17], vec_req(i), 32'(flags()), 32'(VEC[i][23:17]));
            if (VEC[i][23] || VEC[i][22])
                check({bus_write, bus_addr} == VEC[i][16:0], vec_req(i),
                      32'({bus_write, bus_addr}), 32'(VEC[i][16:0]));
        end

        // R1: reset in the middle of an access
        @(negedge clk);
        req_valid = 1'b1; pipe_en = 1'b0; req_addr = 16'h0990; req_write = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #5;
        check(flags() == 7'b0, "R1", 32'(flags()), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: page 0 after reset is still a miss; R3/R4: T1, two waits, one ready
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0050;
        #5;
        check(req_take == 1'b1, "R2", 32'(req_take), 32'h1);
        @(negedge clk);
        req_valid = 1'b0;
        #5;
        check(bus_t1 && !page_hit, "R6", 32'({bus_t1, page_hit}), 32'h2);
        @(negedge clk); #5;
        check(flags() == 7'b0110000, "R3", 32'(flags()), 32'h30);
        @(negedge clk); #5;
        check(flags() == 7'b0110000, "R4", 32'(flags()), 32'h30);
        @(negedge clk); #5;
        check(flags() == 7'b0101000, "R3", 32'(flags()), 32'h28);
        @(negedge clk); #5;
        check(flags() == 7'b0, "R10", 32'(flags()), 32'h0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule